// File: doc/BRIEF.md
# Interrupt Source Router with Round-Robin Delivery

This block holds the per-source configuration of a multi-CPU interrupt controller. It turns each raw interrupt line into a pending state and decides which per-CPU arbiters hear about it. Each source has two registers. The first holds the vector, the priority and the control bits: mask, activity, polarity, sense, mode and non-maskable. The second holds a bitmask of destination CPUs. The per-CPU priority arbitration and the bus decode sit outside this block. They talk to it through a plain write port, a combinational read port and an acknowledge strobe.

Whenever a source's effective input changes, one of its registers is written, or it is acknowledged, the source is flagged for re-evaluation. One flagged source is evaluated per cycle, lowest index first. The evaluation decides whether the source is active and updates its activity bit. It then emits a one-cycle raise strobe (active) or clear strobe (inactive), tagged with the source index, to the chosen CPUs. In directed mode every CPU in the destination mask is strobed. In distributed mode a single CPU is picked by rotating from the CPU served last.

Top module: `isr_router`

## Requirements
- R1: With the sense bit (bit 26 of the control register) set, the source is level-sensitive and its pending state follows the effective input one cycle later. The effective input equals the raw line when the polarity bit (bit 27) is 1 and its inverse when that bit is 0.
- R2: With the sense bit clear, a rising edge of the effective input sets pending, and a falling edge leaves it set. An acknowledge of that source clears it. An acknowledge of a level-sensitive source does not change its pending state.
- R3: A pending source whose mask bit (bit 31) is 1 is evaluated as inactive and receives clear strobes, unless its non-maskable bit (bit 25) is 1.
- R4: Bit 30 of the control register reads back whether the source was active at its latest evaluation. The value written to bit 30 is ignored.
- R5: A source whose destination mask is zero produces no strobe at all.
- R6: With the mode bit (bit 24) clear, an evaluation strobes every CPU whose bit is set in the destination mask.
- R7: With the mode bit set, the search starts at the CPU after the one served last and wraps at the CPU count. The first CPU found in the mask is strobed and becomes the new last-served CPU. After reset the last-served CPU is CPU 0.
- R8: If the destination mask holds only the last-served CPU, that CPU alone is strobed, in either mode, and the last-served CPU is unchanged.
- R9: The destination register keeps only its NUM_CPU low bits. Higher written bits read back as zero.
- R10: Reset loads each control register with mask and polarity set (0x8800_0000) and each destination register with CPU 0 only (0x1), and holds all strobes low.
- R11: A source flagged at clock edge k is strobed by the register output after edge k+1, for exactly one cycle, with its index on dlv_src. When several sources are flagged at once, they are served one per cycle, lowest index first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Raw interrupt lines |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control register, 1 the destination register |
| wr_src | input | SRC_W | Source whose register is written |
| wr_data | input | 32 | Write data |
| rd_src | input | SRC_W | Source whose register is read |
| rd_sel | input | 1 | 0 reads the control register, 1 the destination register |
| rd_data | output | 32 | Combinational read data |
| ack_en | input | 1 | Acknowledge strobe from a CPU arbiter |
| ack_src | input | SRC_W | Source being acknowledged |
| dlv_raise | output | NUM_CPU | One-cycle raise strobe per CPU |
| dlv_clear | output | NUM_CPU | One-cycle clear strobe per CPU |
| dlv_src | output | SRC_W | Index of the source behind the current strobe |

## Verification
The bench sweeps all sixteen destination masks of a four-CPU configuration, first in directed mode and then three evaluations per mask in distributed mode. It predicts the rotation arithmetically and so catches a search that starts at the last CPU instead of the next one, or one that forgets to wrap. It also catches a last-served CPU that is not updated, or one that is updated in the single-CPU shortcut. Edge sources are driven high, then low, then acknowledged. A design that cleared pending on the falling edge, or cleared a level source on acknowledge, would show a stray clear or a missing raise. Writes that set bit 30 on an idle source, and masked sources with and without the non-maskable bit, expose an activity bit that is writable or a mask that wins over non-maskable. Two sources that rise in the same cycle check that they are served in index order and with the stated latency.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int REG_W      = 32;
  localparam int B_MASK     = 31;
  localparam int B_ACT      = 30;
  localparam int B_POL      = 27;
  localparam int B_SENSE    = 26;
  localparam int B_NMI      = 25;
  localparam int B_MODE     = 24;
  localparam int PRIO_LSB   = 16;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_DEST = 1'b1
  } reg_sel_e;

  localparam logic [REG_W-1:0] CTRL_RESET =
    (REG_W'(1) << B_MASK) | (REG_W'(1) << B_POL);
endpackage

// File: rtl/isr_src_slot.sv
module isr_src_slot
  import isr_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int PRIO_W  = 4,
  parameter int VEC_W   = 8,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               raw_in,
  input  logic               wr_ctrl,
  input  logic               wr_dest,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               ack,
  input  logic               eval_en,
  input  logic               act_new,
  input  logic               last_we,
  input  logic [CPU_W-1:0]   last_new,
  output logic [REG_W-1:0]   ctrl_rd,
  output logic [NUM_CPU-1:0] dest_q,
  output logic [CPU_W-1:0]   last_q,
  output logic               dirty_q,
  output logic               active
);
  localparam logic [REG_W-1:0] VEC_FIELD  = (REG_W'(1) << VEC_W) - REG_W'(1);
  localparam logic [REG_W-1:0] PRIO_FIELD = ((REG_W'(1) << PRIO_W) - REG_W'(1)) << PRIO_LSB;
  localparam logic [REG_W-1:0] CTL_BITS   = (REG_W'(1) << B_MASK) | (REG_W'(1) << B_POL) |
                                            (REG_W'(1) << B_SENSE) | (REG_W'(1) << B_NMI) |
                                            (REG_W'(1) << B_MODE);
  localparam logic [REG_W-1:0] WR_MASK    = VEC_FIELD | PRIO_FIELD | CTL_BITS;

  logic [REG_W-1:0]   ctrl_q, ctrl_d;
  logic [NUM_CPU-1:0] dest_d;
  logic [CPU_W-1:0]   last_d;
  logic               act_q, act_d;
  logic               pend_q, pend_d;
  logic               in_q;
  logic               eff_in;
  logic               dirty_d;

  assign eff_in = ctrl_q[B_POL] ? raw_in : ~raw_in;

  always_comb begin
    ctrl_d  = wr_ctrl ? (wr_data & WR_MASK) : ctrl_q;
    dest_d  = wr_dest ? wr_data[NUM_CPU-1:0] : dest_q;
    last_d  = last_we ? last_new : last_q;
    act_d   = eval_en ? act_new : act_q;
    if (ctrl_q[B_SENSE]) begin
      pend_d = eff_in;
    end else if (eff_in && !in_q) begin
      pend_d = 1'b1;
    end else if (ack) begin
      pend_d = 1'b0;
    end else begin
      pend_d = pend_q;
    end
    dirty_d = (dirty_q && !eval_en) || (eff_in != in_q) || wr_ctrl || wr_dest || ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RESET;
      dest_q  <= NUM_CPU'(1);
      last_q  <= '0;
      act_q   <= 1'b0;
      pend_q  <= 1'b0;
      in_q    <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      dest_q  <= dest_d;
      last_q  <= last_d;
      act_q   <= act_d;
      pend_q  <= pend_d;
      in_q    <= eff_in;
      dirty_q <= dirty_d;
    end
  end

  assign active  = pend_q && !(ctrl_q[B_MASK] && !ctrl_q[B_NMI]);
  assign ctrl_rd = ctrl_q | (REG_W'(act_q) << B_ACT);

  // R4: a register write that is not an evaluation leaves the activity bit alone
  a_r4_act_kept_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !eval_en) |=> $stable(act_q));

  // R2: an edge-sensitive pending state holds until acknowledged
  a_r2_edge_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[B_SENSE] && !wr_ctrl && !ack && pend_q) |=> pend_q);
endmodule

// File: rtl/isr_pick.sv
module isr_pick #(
  parameter int N      = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
  assign valid = |req;
endmodule

// File: rtl/isr_route.sv
module isr_route #(
  parameter int NUM_CPU = 4,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic [NUM_CPU-1:0] dest,
  input  logic               distrib,
  input  logic [CPU_W-1:0]   last,
  output logic [NUM_CPU-1:0] tgt,
  output logic               last_we,
  output logic [CPU_W-1:0]   last_new
);
  logic [NUM_CPU-1:0] last_hot;
  logic               hit;
  int                 c;

  assign last_hot = NUM_CPU'(1) << last;

  always_comb begin
    tgt      = '0;
    last_we  = 1'b0;
    last_new = last;
    hit      = 1'b0;
    c        = 0;
    if (dest == '0) begin
      tgt = '0;
    end else if (dest == last_hot) begin
      tgt = last_hot;
    end else if (!distrib) begin
      tgt = dest;
    end else begin
      for (int k = 1; k < NUM_CPU; k++) begin
        c = int'(last) + k;
        if (c >= NUM_CPU) c = c - NUM_CPU;
        if (!hit && dest[c]) begin
          hit      = 1'b1;
          tgt[c]   = 1'b1;
          last_we  = 1'b1;
          last_new = CPU_W'(c);
        end
      end
    end
  end
endmodule

// File: rtl/isr_router.sv
module isr_router
  import isr_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_CPU = 4,
  parameter int PRIO_W  = 4,
  parameter int VEC_W   = 8,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [SRC_W-1:0]   wr_src,
  input  logic [31:0]        wr_data,
  input  logic [SRC_W-1:0]   rd_src,
  input  logic               rd_sel,
  output logic [31:0]        rd_data,
  input  logic               ack_en,
  input  logic [SRC_W-1:0]   ack_src,
  output logic [NUM_CPU-1:0] dlv_raise,
  output logic [NUM_CPU-1:0] dlv_clear,
  output logic [SRC_W-1:0]   dlv_src
);
  logic [REG_W-1:0]   ctrl_a  [NUM_SRC];
  logic [NUM_CPU-1:0] dest_a  [NUM_SRC];
  logic [CPU_W-1:0]   last_a  [NUM_SRC];
  logic [NUM_SRC-1:0] dirty_v;
  logic [NUM_SRC-1:0] active_v;
  logic [NUM_SRC-1:0] eval_v;

  logic               pick_valid;
  logic [SRC_W-1:0]   pick_idx;
  logic [NUM_CPU-1:0] sel_dest;
  logic [REG_W-1:0]   sel_ctrl;
  logic               sel_mode;
  logic               sel_active;
  logic [NUM_CPU-1:0] route_tgt;
  logic               route_last_we;
  logic [CPU_W-1:0]   route_last_new;

  logic [NUM_CPU-1:0] raise_d, clear_d;
  logic [SRC_W-1:0]   src_d;

  isr_pick #(.N(NUM_SRC)) u_pick (
    .req   (dirty_v),
    .valid (pick_valid),
    .idx   (pick_idx)
  );

  assign sel_dest   = dest_a[pick_idx];
  assign sel_ctrl   = ctrl_a[pick_idx];
  assign sel_mode   = sel_ctrl[B_MODE];
  assign sel_active = active_v[pick_idx];

  isr_route #(.NUM_CPU(NUM_CPU)) u_route (
    .dest     (sel_dest),
    .distrib  (sel_mode),
    .last     (last_a[pick_idx]),
    .tgt      (route_tgt),
    .last_we  (route_last_we),
    .last_new (route_last_new)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
    assign eval_v[g] = pick_valid && (pick_idx == SRC_W'(g));

    isr_src_slot #(
      .NUM_CPU (NUM_CPU),
      .PRIO_W  (PRIO_W),
      .VEC_W   (VEC_W)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_in   (src_in[g]),
      .wr_ctrl  (wr_en && wr_sel == SEL_CTRL && wr_src == SRC_W'(g)),
      .wr_dest  (wr_en && wr_sel == SEL_DEST && wr_src == SRC_W'(g)),
      .wr_data  (wr_data),
      .ack      (ack_en && ack_src == SRC_W'(g)),
      .eval_en  (eval_v[g]),
      .act_new  (sel_active),
      .last_we  (eval_v[g] && route_last_we),
      .last_new (route_last_new),
      .ctrl_rd  (ctrl_a[g]),
      .dest_q   (dest_a[g]),
      .last_q   (last_a[g]),
      .dirty_q  (dirty_v[g]),
      .active   (active_v[g])
    );
  end

  assign rd_data = rd_sel ? REG_W'(dest_a[rd_src]) : ctrl_a[rd_src];

  always_comb begin
    raise_d = (pick_valid && sel_active)  ? route_tgt : '0;
    clear_d = (pick_valid && !sel_active) ? route_tgt : '0;
    src_d   = pick_valid ? pick_idx : dlv_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlv_raise <= '0;
      dlv_clear <= '0;
      dlv_src   <= '0;
    end else begin
      dlv_raise <= raise_d;
      dlv_clear <= clear_d;
      dlv_src   <= src_d;
    end
  end

  // R11: a strobe is only ever the result of an evaluation one cycle earlier
  a_r11_strobe_follows_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dlv_raise | dlv_clear)) |-> $past(pick_valid));

  // R6: strobes never reach a CPU outside the evaluated destination mask
  a_r6_inside_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dlv_raise | dlv_clear)) |-> (((dlv_raise | dlv_clear) & ~$past(sel_dest)) == '0));

  // R7: distributed delivery reaches exactly one CPU
  a_r7_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(dlv_raise | dlv_clear)) && $past(sel_mode)) |-> $onehot(dlv_raise | dlv_clear));

  // R5: an empty destination mask yields no strobe
  a_r5_empty_dest_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_valid && sel_dest == '0) |=> (dlv_raise == '0 && dlv_clear == '0));

  // R3: a masked, maskable source is never raised
  a_r3_masked_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_valid && sel_ctrl[B_MASK] && !sel_ctrl[B_NMI]) |=> (dlv_raise == '0));
endmodule

// File: tb/isr_router_tb.sv
module isr_router_tb;
  localparam int NS = 8;
  localparam int NC = 4;
  localparam logic [31:0] C_MASK  = 32'h8000_0000;
  localparam logic [31:0] C_ACT   = 32'h4000_0000;
  localparam logic [31:0] C_POL   = 32'h0800_0000;
  localparam logic [31:0] C_SENSE = 32'h0400_0000;
  localparam logic [31:0] C_NMI   = 32'h0200_0000;
  localparam logic [31:0] C_MODE  = 32'h0100_0000;
  localparam logic [31:0] LVL_HI  = C_SENSE | C_POL;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src_in;
  logic          wr_en, wr_sel, rd_sel, ack_en;
  logic [2:0]    wr_src, rd_src, ack_src;
  logic [31:0]   wr_data, rd_data;
  logic [NC-1:0] dlv_raise, dlv_clear;
  logic [2:0]    dlv_src;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int wcyc  = 0;
  logic [NC-1:0] rlog, clog;
  int nstb;
  int first_cyc, second_cyc;
  logic [2:0] first_src, second_src;
  int mlast;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  isr_router u_dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_src(wr_src), .wr_data(wr_data),
    .rd_src(rd_src), .rd_sel(rd_sel), .rd_data(rd_data),
    .ack_en(ack_en), .ack_src(ack_src),
    .dlv_raise(dlv_raise), .dlv_clear(dlv_clear), .dlv_src(dlv_src)
  );

  always @(negedge clk) begin
    if (|(dlv_raise | dlv_clear)) begin
      rlog = rlog | dlv_raise;
      clog = clog | dlv_clear;
      nstb = nstb + 1;
      if (nstb == 1) begin first_src = dlv_src; first_cyc = cyc; end
      if (nstb == 2) begin second_src = dlv_src; second_cyc = cyc; end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clr_log();
    rlog = '0; clog = '0; nstb = 0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic wr(input int s, input logic sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_src = 3'(s); wr_data = d; wcyc = cyc;
    @(negedge clk);
    wr_en = 1'b0;
    settle();
  endtask

  task automatic set_in(input int s, input logic v);
    @(negedge clk);
    src_in[s] = v;
    settle();
  endtask

  task automatic do_ack(input int s);
    @(negedge clk);
    ack_en = 1'b1; ack_src = 3'(s);
    @(negedge clk);
    ack_en = 1'b0;
    settle();
  endtask

  task automatic rd(input int s, input logic sel, output logic [31:0] v);
    rd_src = 3'(s); rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  function automatic logic [NC-1:0] model(input logic [NC-1:0] d, input bit distrib, inout int last);
    if (d == '0) return '0;
    if (d == (NC'(1) << last)) return d;
    if (!distrib) return d;
    for (int k = 1; k < NC; k++) begin
      if (d[(last + k) % NC]) begin
        last = (last + k) % NC;
        return NC'(1) << last;
      end
    end
    return '0;
  endfunction

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [NC-1:0] e;
    rst_n = 1'b0; src_in = '0; wr_en = 1'b0; wr_sel = 1'b0; wr_src = '0; wr_data = '0;
    rd_src = '0; rd_sel = 1'b0; ack_en = 1'b0; ack_src = '0;
    clr_log();
    repeat (5) @(negedge clk);
    chk("R10", "strobes in reset", 32'(rlog | clog), 32'h0);
    rst_n = 1'b1;
    settle();
    rd(0, 1'b0, v); chk("R10", "ctrl reset", v, 32'h8800_0000);
    rd(7, 1'b1, v); chk("R10", "dest reset", v, 32'h1);
    chk("R10", "strobes after reset", 32'(rlog | clog), 32'h0);

    // R9 destination width
    wr(1, 1'b1, 32'hFFFF_FFFF);
    rd(1, 1'b1, v); chk("R9", "dest truncation", v, 32'hF);

    // R1 level sense with polarity
    wr(2, 1'b1, 32'h2);
    wr(2, 1'b0, LVL_HI | 32'h0005_0000);
    clr_log(); set_in(2, 1'b1);
    chk("R1", "level rise raise", 32'(rlog), 32'h2);
    chk("R1", "level rise clear", 32'(clog), 32'h0);
    chk("R11", "source index", 32'(first_src), 32'd2);
    rd(2, 1'b0, v); chk("R4", "act set", 32'(v[30]), 32'h1);
    clr_log(); set_in(2, 1'b0);
    chk("R1", "level fall clear", 32'(clog), 32'h2);
    chk("R1", "level fall raise", 32'(rlog), 32'h0);
    rd(2, 1'b0, v); chk("R4", "act cleared", 32'(v[30]), 32'h0);
    clr_log(); wr(2, 1'b0, C_SENSE);
    chk("R1", "active-low raise", 32'(rlog), 32'h2);
    clr_log(); set_in(2, 1'b1);
    chk("R1", "active-low clear", 32'(clog), 32'h2);
    wr(2, 1'b0, LVL_HI);
    rd(2, 1'b0, v); chk("R1", "active after polarity back", 32'(v[30]), 32'h1);

    // R4 activity bit is not writable
    wr(2, 1'b0, LVL_HI);
    rd(2, 1'b0, v); chk("R4", "write 0 keeps act", v, LVL_HI | C_ACT);
    wr(0, 1'b0, C_MASK | C_POL | C_ACT);
    rd(0, 1'b0, v); chk("R4", "write 1 ignored", v, 32'h8800_0000);

    // R2 edge sense
    wr(3, 1'b1, 32'h1);
    wr(3, 1'b0, C_POL);
    clr_log(); set_in(3, 1'b1);
    chk("R2", "edge raise", 32'(rlog), 32'h1);
    clr_log(); set_in(3, 1'b0);
    chk("R2", "fall keeps pending, no clear", 32'(clog), 32'h0);
    rd(3, 1'b0, v); chk("R2", "still active", 32'(v[30]), 32'h1);
    clr_log(); do_ack(3);
    chk("R2", "ack clears", 32'(clog), 32'h1);
    chk("R2", "ack no raise", 32'(rlog), 32'h0);
    rd(3, 1'b0, v); chk("R2", "inactive after ack", 32'(v[30]), 32'h0);
    clr_log(); do_ack(2);
    chk("R2", "level ack ignored", 32'(rlog), 32'h2);
    chk("R2", "level ack no clear", 32'(clog), 32'h0);

    // R3 mask and non-maskable
    set_in(3, 1'b1);
    clr_log(); wr(3, 1'b0, C_POL | C_MASK);
    chk("R3", "masked clear", 32'(clog), 32'h1);
    chk("R3", "masked no raise", 32'(rlog), 32'h0);
    clr_log(); wr(3, 1'b0, C_POL | C_MASK | C_NMI);
    chk("R3", "nmi raises", 32'(rlog), 32'h1);

    // R5 empty destination
    clr_log(); wr(2, 1'b1, 32'h0);
    chk("R5", "no strobes", 32'(nstb), 32'd0);

    // R11 order and latency
    wr(5, 1'b1, 32'h1); wr(5, 1'b0, LVL_HI);
    wr(6, 1'b1, 32'h4); wr(6, 1'b0, LVL_HI);
    clr_log();
    @(negedge clk); src_in[5] = 1'b1; src_in[6] = 1'b1; wcyc = cyc;
    settle();
    chk("R11", "first src", 32'(first_src), 32'd5);
    chk("R11", "first cycle", 32'(first_cyc), 32'(wcyc + 2));
    chk("R11", "second src", 32'(second_src), 32'd6);
    chk("R11", "second cycle", 32'(second_cyc), 32'(wcyc + 3));
    chk("R11", "both raised", 32'(rlog), 32'h5);
    chk("R11", "one strobe each", 32'(nstb), 32'd2);

    // R6 / R8 directed sweep
    set_in(4, 1'b1);
    wr(4, 1'b0, LVL_HI);
    mlast = 0;
    for (int d = 0; d < 16; d++) begin
      clr_log(); wr(4, 1'b1, 32'(d));
      e = model(NC'(d), 1'b0, mlast);
      chk("R6", $sformatf("directed dest=%0d", d), 32'(rlog), 32'(e));
      chk("R6", "directed no clear", 32'(clog), 32'h0);
      if (d == 1) chk("R11", "write latency", 32'(first_cyc), 32'(wcyc + 2));
    end

    // R7 / R8 distributed sweep
    clr_log(); wr(4, 1'b0, LVL_HI | C_MODE);
    e = model(NC'(15), 1'b1, mlast);
    chk("R7", "mode switch eval", 32'(rlog), 32'(e));
    for (int d = 0; d < 16; d++) begin
      for (int r = 0; r < 3; r++) begin
        clr_log();
        if (r == 0) wr(4, 1'b1, 32'(d));
        else        wr(4, 1'b0, LVL_HI | C_MODE);
        e = model(NC'(d), 1'b1, mlast);
        chk((d == 0) ? "R5" : "R7", $sformatf("distrib dest=%0d rep=%0d", d, r), 32'(rlog), 32'(e));
      end
    end
    // R8: single last CPU repeats
    clr_log(); wr(4, 1'b1, 32'(1 << mlast));
    chk("R8", "only last cpu", 32'(rlog), 32'(1 << mlast));
    clr_log(); wr(4, 1'b0, LVL_HI | C_MODE);
    chk("R8", "only last cpu again", 32'(rlog), 32'(1 << mlast));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule